// File: doc/BRIEF.md
# DMA Control and Status Register

This block is the single 32-bit control and status word of a bus-master DMA engine. Software reaches it through a plain register port: a write strobe with 32 bits of write data, and a readback word that always shows the current register contents. The stored fields feed the engine directly. These fields are the four-bit bus command, the transfer enable, the wide-transfer select and eight active-low byte-lane enables. A direction signal comes from the command's lowest bit.

Two interrupt sources are tracked in sticky status bits. One is the completion of a DMA cycle. The other is an active-low interrupt line from the backend logic. Software clears each status bit by writing one to it. Each status bit has its own enable, and the two gated sources are merged into a single interrupt output.

Writing one to the flush bit produces a one-cycle strobe that empties the engine's FIFOs. The strobe fires only while the FIFO recovery feature is enabled. A parameter picks a 64-bit or a 32-bit core; in the 32-bit build, the fields that only make sense on a wide bus are fixed at zero.

Top module: `dma_csr`

## Requirements
- R1: While reset is asserted and after it is released, the readback is 0, and every output is 0: command, direction, enable, wide select, byte enables, flush strobe and interrupt.
- R2: Bits 7:4 hold the bus command. They are read/write and appear on `bus_cmd` from the cycle after the write. `dir_to_bus` equals bit 4: 0 means data moves from bus to backend (read-type codes such as 0010, 0110, 1010, 1100), and 1 means backend to bus (write-type codes such as 0011, 0111, 1011).
- R3: Bit 8 is the transfer enable. It is read/write and drives `dma_en`.
- R4: Bit 9 selects a 64-bit transfer and drives `wide_xfer`. It is read/write in the 64-bit build. In the 32-bit build, writes to it are ignored and it reads 0.
- R5: `fifo_flush` is high in exactly the cycle of a write whose bit 10 is 1 while `recov_en` is 1. Bit 10 always reads 0.
- R6: Bits 23:16 drive `byte_en_n[7:0]` directly, with bit 16 driving lane 0 and each following bit driving the next lane. In the 32-bit build, bits 23:20 ignore writes, read 0 and drive 0.
- R7: Bits 11, 25:24 and 31:26 ignore writes and always read 0.
- R8: Bit 12 sets one cycle after a `dma_done` pulse and is cleared by writing 1 to it. If a set and a clear fall in the same cycle, the set wins. Bit 13, its enable, is read/write.
- R9: Bit 14 sets on a clock edge where `ext_irq_n` is 0 and bit 15 (its enable, read/write) already holds 1. While bit 15 is 0, bit 14 cannot set. It is cleared by writing 1 to it, and a set wins over a clear in the same cycle.
- R10: `irq` equals (bit 12 AND bit 13) OR (bit 14 AND bit 15).
- R11: Writing 1 to bit 12 or bit 14 never sets it, and writing 0 to either never clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Current register contents |
| dma_done | input | 1 | One-cycle pulse when a DMA cycle completes |
| ext_irq_n | input | 1 | Active-low backend interrupt request, synchronous to clk |
| recov_en | input | 1 | FIFO recovery feature enabled |
| bus_cmd | output | 4 | Bus command for the transfer |
| dir_to_bus | output | 1 | 1 = backend to bus, 0 = bus to backend |
| dma_en | output | 1 | Transfer enable |
| wide_xfer | output | 1 | 64-bit transfer select |
| byte_en_n | output | 8 | Active-low byte-lane enables |
| fifo_flush | output | 1 | One-cycle FIFO flush strobe |
| irq | output | 1 | Combined interrupt |

## Verification
Each status bit can receive a hardware set event and a software write-one-to-clear in the same cycle. The bench provokes this by driving `dma_done` together with a write that has bit 12 at 1. It also holds `ext_irq_n` low while writing 1 to bit 14 with the enable on, and the expected outcome is that the bit stays set. A second collision is a write that clears the backend enable on the same edge as a backend request. Because the enable is sampled before the write lands, that edge must still set the status bit. Both the 64-bit and 32-bit builds are compared against a behavioural model every cycle.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

  localparam int unsigned CSR_W     = 32;
  localparam int unsigned CMD_W     = 4;
  localparam int unsigned LANES     = 8;

  localparam int unsigned CMD_LSB   = 4;
  localparam int unsigned EN_BIT    = 8;
  localparam int unsigned WIDE_BIT  = 9;
  localparam int unsigned FLUSH_BIT = 10;
  localparam int unsigned DONE_ST   = 12;
  localparam int unsigned DONE_EN   = 13;
  localparam int unsigned BE_ST     = 14;
  localparam int unsigned BE_EN     = 15;
  localparam int unsigned LANE_LSB  = 16;

  typedef struct packed {
    logic [CMD_W-1:0] cmd;
    logic             en;
    logic             wide;
    logic [LANES-1:0] lanes_n;
    logic             done_ie;
    logic             ext_ie;
  } ctrl_t;

endpackage

// File: rtl/dma_csr_fields.sv
module dma_csr_fields
  import dma_csr_pkg::*;
#(
  parameter bit WIDE64 = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CSR_W-1:0] wr_data,
  output ctrl_t            ctrl
);

  localparam int unsigned LANE_W = WIDE64 ? LANES : LANES / 2;

  logic [CMD_W-1:0]  cmd_q, cmd_d;
  logic              en_q, en_d;
  logic              done_ie_q, done_ie_d;
  logic              ext_ie_q, ext_ie_d;
  logic [LANE_W-1:0] lane_q, lane_d;

  always_comb begin
    cmd_d     = cmd_q;
    en_d      = en_q;
    done_ie_d = done_ie_q;
    ext_ie_d  = ext_ie_q;
    lane_d    = lane_q;
    if (wr_en) begin
      cmd_d     = wr_data[CMD_LSB +: CMD_W];
      en_d      = wr_data[EN_BIT];
      done_ie_d = wr_data[DONE_EN];
      ext_ie_d  = wr_data[BE_EN];
      lane_d    = wr_data[LANE_LSB +: LANE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      en_q      <= 1'b0;
      done_ie_q <= 1'b0;
      ext_ie_q  <= 1'b0;
      lane_q    <= '0;
    end else if (wr_en) begin
      cmd_q     <= cmd_d;
      en_q      <= en_d;
      done_ie_q <= done_ie_d;
      ext_ie_q  <= ext_ie_d;
      lane_q    <= lane_d;
    end
  end

  generate
    if (WIDE64) begin : g_wide
      logic wide_q, wide_d;
      always_comb begin
        wide_d = wide_q;
        if (wr_en) wide_d = wr_data[WIDE_BIT];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     wide_q <= 1'b0;
        else if (wr_en) wide_q <= wide_d;
      end
      assign ctrl.wide    = wide_q;
      assign ctrl.lanes_n = lane_q;
    end else begin : g_narrow
      assign ctrl.wide    = 1'b0;
      assign ctrl.lanes_n = {{(LANES - LANE_W){1'b0}}, lane_q};
    end
  endgenerate

  assign ctrl.cmd     = cmd_q;
  assign ctrl.en      = en_q;
  assign ctrl.done_ie = done_ie_q;
  assign ctrl.ext_ie  = ext_ie_q;

endmodule

// File: rtl/dma_csr_w1c.sv
module dma_csr_w1c (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q, flag_d, upd;

  assign upd = set_i | clr_i;

  always_comb begin
    flag_d = flag_q;
    if (set_i)      flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag_q <= 1'b0;
    else if (upd) flag_q <= flag_d;
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/dma_csr_flush.sv
module dma_csr_flush
  import dma_csr_pkg::*;
(
  input  logic             wr_en,
  input  logic [CSR_W-1:0] wr_data,
  input  logic             recov_en,
  output logic             flush_o
);

  assign flush_o = wr_en & wr_data[FLUSH_BIT] & recov_en;

endmodule

// File: rtl/dma_csr.sv
module dma_csr
  import dma_csr_pkg::*;
#(
  parameter bit WIDE64 = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic        dma_done,
  input  logic        ext_irq_n,
  input  logic        recov_en,
  output logic [3:0]  bus_cmd,
  output logic        dir_to_bus,
  output logic        dma_en,
  output logic        wide_xfer,
  output logic [7:0]  byte_en_n,
  output logic        fifo_flush,
  output logic        irq
);

  ctrl_t ctrl;
  logic  done_st, ext_st;
  logic  ext_set;

  dma_csr_fields #(.WIDE64(WIDE64)) u_fields (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .ctrl    (ctrl)
  );

  // enable is sampled before any write in the same cycle lands
  assign ext_set = ~ext_irq_n & ctrl.ext_ie;

  dma_csr_w1c u_done_st (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (dma_done),
    .clr_i  (wr_en & wr_data[DONE_ST]),
    .flag_o (done_st)
  );

  dma_csr_w1c u_ext_st (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (ext_set),
    .clr_i  (wr_en & wr_data[BE_ST]),
    .flag_o (ext_st)
  );

  dma_csr_flush u_flush (
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .recov_en (recov_en),
    .flush_o  (fifo_flush)
  );

  always_comb begin
    rd_data                              = '0;
    rd_data[CMD_LSB +: CMD_W]            = ctrl.cmd;
    rd_data[EN_BIT]                      = ctrl.en;
    rd_data[WIDE_BIT]                    = ctrl.wide;
    rd_data[DONE_ST]                     = done_st;
    rd_data[DONE_EN]                     = ctrl.done_ie;
    rd_data[BE_ST]                       = ext_st;
    rd_data[BE_EN]                       = ctrl.ext_ie;
    rd_data[LANE_LSB +: LANES]           = ctrl.lanes_n;
  end

  assign bus_cmd    = ctrl.cmd;
  assign dir_to_bus = ctrl.cmd[0];
  assign dma_en     = ctrl.en;
  assign wide_xfer  = ctrl.wide;
  assign byte_en_n  = ctrl.lanes_n;
  assign irq        = (done_st & ctrl.done_ie) | (ext_st & ctrl.ext_ie);

endmodule

// File: rtl/dma_csr_chk.sv
module dma_csr_chk #(
  parameter bit WIDE64 = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        dma_done,
  input logic        ext_irq_n,
  input logic [3:0]  bus_cmd,
  input logic        dir_to_bus,
  input logic        wide_xfer,
  input logic        irq
);

  // R2
  dir_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_to_bus == bus_cmd[0]);

  // R5
  flush_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[10] == 1'b0);

  // R7
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & 32'hFF00_0800) == 32'h0);

  // R8
  done_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done |=> rd_data[12]);

  // R9
  ext_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_irq_n && rd_data[15]) |=> rd_data[14]);

  // R9
  ext_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[15] && !rd_data[14]) |=> !rd_data[14]);

  // R10
  irq_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ((rd_data[12] & rd_data[13]) | (rd_data[14] & rd_data[15])));

  // R11
  zero_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[12] && rd_data[12]) |=> rd_data[12]);

  // R11
  one_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !dma_done && !rd_data[12]) |=> !rd_data[12]);

  generate
    if (!WIDE64) begin : g_narrow_chk
      // R4
      narrow_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_xfer && !rd_data[9]);
      // R6
      narrow_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[23:20] == 4'h0);
    end
  endgenerate

endmodule

bind dma_csr dma_csr_chk #(.WIDE64(WIDE64)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .rd_data    (rd_data),
  .dma_done   (dma_done),
  .ext_irq_n  (ext_irq_n),
  .bus_cmd    (bus_cmd),
  .dir_to_bus (dir_to_bus),
  .wide_xfer  (wide_xfer),
  .irq        (irq)
);

// File: tb/dma_csr_tb_top.sv
module dma_csr_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        dma_done = 1'b0;
  logic        ext_irq_n = 1'b1;
  logic        recov_en = 1'b0;

  logic [31:0] rd_a, rd_b;
  logic [3:0]  cmd_a, cmd_b;
  logic        dir_a, dir_b, en_a, en_b, wide_a, wide_b;
  logic [7:0]  be_a, be_b;
  logic        fl_a, fl_b, irq_a, irq_b;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  dma_csr #(.WIDE64(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_a),
    .dma_done(dma_done), .ext_irq_n(ext_irq_n), .recov_en(recov_en),
    .bus_cmd(cmd_a), .dir_to_bus(dir_a), .dma_en(en_a), .wide_xfer(wide_a),
    .byte_en_n(be_a), .fifo_flush(fl_a), .irq(irq_a)
  );

  dma_csr #(.WIDE64(1'b0)) dut32_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_b),
    .dma_done(dma_done), .ext_irq_n(ext_irq_n), .recov_en(recov_en),
    .bus_cmd(cmd_b), .dir_to_bus(dir_b), .dma_en(en_b), .wide_xfer(wide_b),
    .byte_en_n(be_b), .fifo_flush(fl_b), .irq(irq_b)
  );

  // behavioural reference: one word per build
  logic [31:0] m64 = '0, m32 = '0;

  function automatic logic [31:0] step(input logic [31:0] cur, input bit wide);
    logic [31:0] rw, nx;
    rw = wide ? 32'h00FF_A3F0 : 32'h000F_A1F0;
    nx = cur;
    if (wr_en) nx = (cur & ~rw) | (wr_data & rw);
    nx[12] = dma_done | (cur[12] & ~(wr_en & wr_data[12]));
    nx[14] = (~ext_irq_n & cur[15]) | (cur[14] & ~(wr_en & wr_data[14]));
    return nx;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m64 <= '0;
      m32 <= '0;
    end else begin
      m64 <= step(m64, 1'b1);
      m32 <= step(m32, 1'b0);
    end
  end

  task automatic chk(input string tag, input string who, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", tag, who, act, exp, $time);
    end
  endtask

  task automatic cmp(input string who, input logic [31:0] m, input logic [31:0] rd,
                     input logic [3:0] cmd, input logic dir, input logic en,
                     input logic wide, input logic [7:0] be, input logic fl,
                     input logic iq);
    if (!rst_n) chk("R1", who, rd, 32'h0);
    chk("R8", who, rd, m);
    chk("R7", who, rd & 32'hFF00_0800, 32'h0);
    chk("R5", who, {31'b0, rd[10]}, 32'h0);
    chk("R2", who, {27'b0, cmd, dir}, {27'b0, m[7:4], m[4]});
    chk("R3", who, {31'b0, en}, {31'b0, m[8]});
    chk("R4", who, {31'b0, wide}, {31'b0, m[9]});
    chk("R6", who, {24'b0, be}, {24'b0, m[23:16]});
    chk("R5", who, {31'b0, fl}, {31'b0, wr_en & wr_data[10] & recov_en});
    chk("R10", who, {31'b0, iq}, {31'b0, (m[12] & m[13]) | (m[14] & m[15])});
  endtask

  always @(negedge clk) begin
    cycles++;
    cmp("w64", m64, rd_a, cmd_a, dir_a, en_a, wide_a, be_a, fl_a, irq_a);
    cmp("w32", m32, rd_b, cmd_b, dir_b, en_b, wide_b, be_b, fl_b, irq_b);
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin : watchdog
    #50000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  logic [3:0] codes [7] = '{4'b0010, 4'b0011, 4'b0110, 4'b0111, 4'b1010, 4'b1011, 4'b1100};

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R2 R3 R6: recommended command codes with enable and lane patterns
    for (int k = 0; k < 7; k++) begin
      wr({8'h0, 8'hA5 ^ 8'(k), 7'b0, 1'b1, codes[k], 4'h0});
      idle(1);
    end

    // R4 R6 R7: all ones without recovery, then with recovery (R5)
    wr(32'hFFFF_BBFF);
    recov_en = 1'b1;
    wr(32'hFFFF_0FFF);
    wr(32'h0000_0400);
    recov_en = 1'b0;
    wr(32'h0000_0400);
    wr(32'h0);

    // R8: completion sets, enable raises irq, W1C clears
    @(posedge clk); #1 dma_done = 1'b1;
    @(posedge clk); #1 dma_done = 1'b0;
    wr(32'h0000_2000);
    // R11: writing zero keeps status, writing one never sets
    wr(32'h0000_2000);
    wr(32'h0000_3000);
    wr(32'h0000_3000);
    // R8: set and clear in the same cycle, set wins
    @(posedge clk); #1 dma_done = 1'b1;
    @(posedge clk); #1 wr_en = 1'b1; wr_data = 32'h0000_3000;
    @(posedge clk); #1 dma_done = 1'b0; wr_en = 1'b0; wr_data = '0;
    wr(32'h0000_1000);

    // R9: gated while enable off
    ext_irq_n = 1'b0;
    idle(3);
    ext_irq_n = 1'b1;
    wr(32'h0000_8000);
    ext_irq_n = 1'b0;
    idle(2);
    // R9: clear while request held, set wins
    wr(32'h0000_C000);
    ext_irq_n = 1'b1;
    wr(32'h0000_C000);
    // R9: enable turned off on the same edge as a request
    @(posedge clk); #1 ext_irq_n = 1'b0; wr_en = 1'b1; wr_data = 32'h0;
    @(posedge clk); #1 ext_irq_n = 1'b1; wr_en = 1'b0;
    idle(2);
    wr(32'h0000_4000);

    // R1: reset in the middle of activity
    wr(32'h00FF_A3F0);
    @(posedge clk); #1 dma_done = 1'b1;
    @(posedge clk); #1 dma_done = 1'b0; rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule